// File: doc/BRIEF.md
# RGB Dimmer with Blink Patterns

The block drives three LED lines (red, green, blue). Each line takes an 8-bit control byte. The lower four bits pick a brightness from a fixed perceptual (roughly logarithmic) table of 10-bit duties. The upper four bits pick a 16-bit on/off pattern. The pattern turns left by one bit on every pulse of a slow tick input, and the bit that leaves the top end gates that line's PWM output until the next tick.

Control bytes are not used while they sit at the inputs. A one-cycle load strobe copies all three bytes into a pending slot. In the cycle that follows, the patterns and the duty targets of all three lines are replaced together, and the pending slot clears itself. Each line has a free-running 10-bit PWM counter: 256 major steps, each made of 4 fine steps. The three counters start a third of a period apart, so the lines do not all switch on in the same clock. A new duty reaches the comparator only when that line's counter wraps.

Top module: `rgb_blink_dimmer`

## Requirements
- R1: Duty code n (control bits 3:0) selects a 10-bit duty from this list, for n = 0 to 15: 0, 1, 2, 4, 6, 10, 16, 25, 40, 64, 101, 161, 256, 406, 644, 1023. With the pattern gate open, a line is high for exactly that many cycles of every 1024-cycle period.
- R2: Pattern code n (control bits 7:4) selects, for n = 0 to 15: 0xFFFF, 0x00FF, 0x0F0F, 0x3333, 0x5555, 0x000F, 0x0003, 0x0001, 0x0000, 0xFF00, 0xF0F0, 0xCCCC, 0xAAAA, 0xFFF0, 0xFFFC, 0xFFFE.
- R3: Each cycle with `tick` high (and no load being applied) turns every pattern left by one bit. The gate is bit 0 of the pattern, which is the bit that just left the MSB. Right after a load, the gate is bit 0 of the new pattern.
- R4: Asserting `load_stb` in a cycle captures all three control bytes. The next cycle replaces the patterns and duty targets of all three lines at once. Changing the control bytes without a strobe has no effect on the outputs.
- R5: A tick that coincides with the cycle in which a load is applied is ignored. The freshly loaded pattern is not turned.
- R6: Each PWM counter counts 0 to 1023 and wraps. The counters of red, green and blue reset to 0, 340 and 680 (major phase 0x00, 0x55, 0xAA). A line's compare is active while its counter is below its active duty.
- R7: After reset every pattern is 0xFFFF, every duty is 0, no load is pending, and all outputs are low.
- R8: A line's active duty takes its new target only in the cycle its counter wraps from 1023 to 0. Earlier in the running period the old duty still applies.
- R9: A line's output is high only when its PWM compare is active and its pattern gate bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_r | input | 8 | Red control byte: [7:4] pattern code, [3:0] duty code |
| ctrl_g | input | 8 | Green control byte, same layout |
| ctrl_b | input | 8 | Blue control byte, same layout |
| load_stb | input | 1 | One-cycle strobe that captures the control bytes |
| tick | input | 1 | Slow pattern step pulse |
| led_out | output | 3 | Gated PWM lines: bit 0 red, bit 1 green, bit 2 blue |

## Verification
A load strobe seen at clock edge k changes the pattern gate in the output directly after edge k+1. A tick seen at edge k changes the gate directly after edge k. A new duty shows only after the edge at which the line's counter passes from 1023 to 0. The bench keeps a behavioural model that applies these same latencies edge by edge. It compares all three lines on the falling edge after every rising edge. Its directed checks count high cycles over whole 1024-cycle windows, and each window is opened only after a wrap has certainly passed and no tick is pending, so every count is free of the latency.

// File: rtl/rgb_dim_pkg.sv
package rgb_dim_pkg;

    localparam int NCH     = 3;
    localparam int CNT_W   = 10;
    localparam int PAT_W   = 16;
    localparam int CODE_W  = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam int MAJOR_N = 1 << (CNT_W - 2);

    typedef logic [CNT_W-1:0]  duty_t;
    typedef logic [PAT_W-1:0]  pat_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t pat_code;
        code_t duty_code;
    } ctrl_t;

    function automatic duty_t duty_lut(input code_t c);
        duty_t d;
        case (c)
            4'd0:  d = duty_t'(0);
            4'd1:  d = duty_t'(1);
            4'd2:  d = duty_t'(2);
            4'd3:  d = duty_t'(4);
            4'd4:  d = duty_t'(6);
            4'd5:  d = duty_t'(10);
            4'd6:  d = duty_t'(16);
            4'd7:  d = duty_t'(25);
            4'd8:  d = duty_t'(40);
            4'd9:  d = duty_t'(64);
            4'd10: d = duty_t'(101);
            4'd11: d = duty_t'(161);
            4'd12: d = duty_t'(256);
            4'd13: d = duty_t'(406);
            4'd14: d = duty_t'(644);
            default: d = duty_t'(1023);
        endcase
        return d;
    endfunction

    function automatic pat_t pat_lut(input code_t c);
        pat_t p;
        case (c)
            4'h0: p = 16'hFFFF;
            4'h1: p = 16'h00FF;
            4'h2: p = 16'h0F0F;
            4'h3: p = 16'h3333;
            4'h4: p = 16'h5555;
            4'h5: p = 16'h000F;
            4'h6: p = 16'h0003;
            4'h7: p = 16'h0001;
            4'h8: p = 16'h0000;
            4'h9: p = 16'hFF00;
            4'hA: p = 16'hF0F0;
            4'hB: p = 16'hCCCC;
            4'hC: p = 16'hAAAA;
            4'hD: p = 16'hFFF0;
            4'hE: p = 16'hFFFC;
            default: p = 16'hFFFE;
        endcase
        return p;
    endfunction

    function automatic pat_t rotl1(input pat_t p);
        return {p[PAT_W-2:0], p[PAT_W-1]};
    endfunction

    function automatic duty_t phase_of(input int idx);
        return duty_t'(((idx * MAJOR_N) / NCH) * 4);
    endfunction

endpackage

// File: rtl/rgb_load_ctrl.sv
module rgb_load_ctrl
    import rgb_dim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_stb,
    input  ctrl_t ctrl_in  [NCH],
    output logic  apply,
    output ctrl_t ctrl_hold [NCH]
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            for (int i = 0; i < NCH; i++) ctrl_hold[i] <= '0;
        end else begin
            pend_q <= load_stb;
            if (load_stb) begin
                for (int i = 0; i < NCH; i++) ctrl_hold[i] <= ctrl_in[i];
            end
        end
    end

    assign apply = pend_q;

    // R4
    apply_src_chk: assert property (@(posedge clk) disable iff (rst)
        apply |-> $past(load_stb));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !load_stb |=> $stable(ctrl_hold[0]) && $stable(ctrl_hold[NCH-1]));

endmodule

// File: rtl/rgb_pattern_reg.sv
module rgb_pattern_reg
    import rgb_dim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  apply,
    input  logic  tick,
    input  code_t code,
    output logic  gate
);

    pat_t pat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '1;
        end else if (apply) begin
            pat_q <= pat_lut(code);
        end else if (tick) begin
            pat_q <= rotl1(pat_q);
        end
    end

    assign gate = pat_q[0];

    // R3
    rot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !apply) |=> (pat_q == rotl1($past(pat_q))));

    // R5
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        apply |=> (pat_q == pat_lut($past(code))));

endmodule

// File: rtl/rgb_pwm_chan.sv
module rgb_pwm_chan
    import rgb_dim_pkg::*;
#(
    parameter duty_t PHASE = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  apply,
    input  code_t code,
    output logic  cmp_on
);

    localparam duty_t TOP = duty_t'(CNT_MAX);

    duty_t cnt_q;
    duty_t duty_nxt_q;
    duty_t duty_act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= PHASE;
            duty_nxt_q <= '0;
            duty_act_q <= '0;
        end else begin
            cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + duty_t'(1);
            if (apply)        duty_nxt_q <= duty_lut(code);
            if (cnt_q == TOP) duty_act_q <= duty_nxt_q;
        end
    end

    assign cmp_on = (cnt_q < duty_act_q);

    // R6
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP) |=> (cnt_q == '0));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + duty_t'(1)));

    // R8
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(duty_act_q));

endmodule

// File: rtl/rgb_blink_dimmer.sv
module rgb_blink_dimmer
    import rgb_dim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] ctrl_r,
    input  logic [7:0] ctrl_g,
    input  logic [7:0] ctrl_b,
    input  logic       load_stb,
    input  logic       tick,
    output logic [2:0] led_out
);

    ctrl_t ctrl_arr  [NCH];
    ctrl_t ctrl_hold [NCH];
    logic  apply;
    logic [NCH-1:0] cmp_on;
    logic [NCH-1:0] gate;

    assign ctrl_arr[0] = ctrl_t'(ctrl_r);
    assign ctrl_arr[1] = ctrl_t'(ctrl_g);
    assign ctrl_arr[2] = ctrl_t'(ctrl_b);

    rgb_load_ctrl u_load (
        .clk       (clk),
        .rst       (rst),
        .load_stb  (load_stb),
        .ctrl_in   (ctrl_arr),
        .apply     (apply),
        .ctrl_hold (ctrl_hold)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        rgb_pwm_chan #(
            .PHASE (phase_of(i))
        ) u_pwm (
            .clk    (clk),
            .rst    (rst),
            .apply  (apply),
            .code   (ctrl_hold[i].duty_code),
            .cmp_on (cmp_on[i])
        );

        rgb_pattern_reg u_pat (
            .clk   (clk),
            .rst   (rst),
            .apply (apply),
            .tick  (tick),
            .code  (ctrl_hold[i].pat_code),
            .gate  (gate[i])
        );
    end

    assign led_out = cmp_on & gate;

    // R9
    out_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(led_out) <= $countones(gate));

endmodule

// File: tb/rgb_blink_dimmer_bench.sv
module rgb_blink_dimmer_bench;

    localparam int DUTY_T [16] = '{0, 1, 2, 4, 6, 10, 16, 25, 40, 64, 101, 161, 256, 406, 644, 1023};
    localparam int PAT_T  [16] = '{'hFFFF, 'h00FF, 'h0F0F, 'h3333, 'h5555, 'h000F, 'h0003, 'h0001,
                                   'h0000, 'hFF00, 'hF0F0, 'hCCCC, 'hAAAA, 'hFFF0, 'hFFFC, 'hFFFE};
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] c_r = '0, c_g = '0, c_b = '0;
    logic       load_stb = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] led_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit live   = 1'b0;
    bit done   = 1'b0;

    int m_cnt [3];
    int m_dn  [3];
    int m_da  [3];
    int m_pat [3];
    int m_sh  [3];
    bit m_pend;

    always #5 clk = ~clk;

    rgb_blink_dimmer u_rgb_blink_dimmer (
        .clk      (clk),
        .rst      (rst),
        .ctrl_r   (c_r),
        .ctrl_g   (c_g),
        .ctrl_b   (c_b),
        .load_stb (load_stb),
        .tick     (tick),
        .led_out  (led_out)
    );

    // reference model: state after every rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = ((i * 256) / 3) * 4;
                m_dn[i] = 0; m_da[i] = 0; m_pat[i] = 'hFFFF; m_sh[i] = 0;
            end
            m_pend = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (m_cnt[i] == 1023) begin
                    m_cnt[i] = 0;
                    m_da[i] = m_dn[i];
                end else begin
                    m_cnt[i]++;
                end
                if (m_pend) begin
                    m_pat[i] = PAT_T[(m_sh[i] >> 4) & 15];
                    m_dn[i]  = DUTY_T[m_sh[i] & 15];
                end else if (tick) begin
                    m_pat[i] = ((m_pat[i] << 1) | (m_pat[i] >> 15)) & 'hFFFF;
                end
            end
            if (load_stb) begin
                m_sh[0] = c_r; m_sh[1] = c_g; m_sh[2] = c_b;
            end
            m_pend = load_stb;
        end
    end

    // per-cycle comparison against the model (R6, R8, R9 timing)
    always @(negedge clk) begin
        if (live && !done) begin
            for (int i = 0; i < 3; i++) begin
                bit exp_b;
                exp_b = (m_cnt[i] < m_da[i]) && ((m_pat[i] & 1) != 0);
                checks++;
                if (led_out[i] !== exp_b) begin
                    fails++;
                    $display("FAIL R6/R8/R9 cycle %0d ch%0d actual %0b expected %0b", cyc, i, led_out[i], exp_b);
                end
            end
        end
        if (cyc >= LIMIT && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic count_high(input int ch, output int n);
        n = 0;
        repeat (1024) begin
            @(negedge clk);
            n += led_out[ch];
        end
    endtask

    task automatic do_load(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        @(negedge clk);
        c_r = r; c_g = g; c_b = b;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;

        // R7: reset state, all lines dark
        for (int i = 0; i < 3; i++) begin
            count_high(i, n);
            check_eq($sformatf("R7 reset ch%0d high count", i), n, 0);
        end

        // R1: duty table through all three lines
        do_load(8'h0F, 8'h0C, 8'h05);
        repeat (2100) @(negedge clk);
        count_high(0, n); check_eq("R1 red code 15", n, 1023);
        count_high(1, n); check_eq("R1 green code 12", n, 256);
        count_high(2, n); check_eq("R1 blue code 5", n, 10);

        // R4: bytes changed without strobe have no effect
        @(negedge clk);
        c_r = 8'h80; c_g = 8'h00; c_b = 8'h81;
        repeat (2100) @(negedge clk);
        count_high(0, n); check_eq("R4 red unchanged", n, 1023);
        count_high(1, n); check_eq("R4 green unchanged", n, 256);

        // R1: further codes
        do_load(8'h09, 8'h01, 8'h0E);
        repeat (2100) @(negedge clk);
        count_high(0, n); check_eq("R1 red code 9", n, 64);
        count_high(1, n); check_eq("R1 green code 1", n, 1);
        count_high(2, n); check_eq("R1 blue code 14", n, 644);

        // R2/R3: patterns 0x00FF, 0xCCCC, 0x0003 at full duty, stepped by ticks
        do_load(8'h1F, 8'hBF, 8'h6F);
        repeat (2100) @(negedge clk);
        for (int k = 0; k <= 16; k++) begin
            if (k > 0) do_tick();
            for (int i = 0; i < 3; i++) begin
                int p;
                int bitv;
                p = (i == 0) ? 'h00FF : (i == 1) ? 'hCCCC : 'h0003;
                bitv = (p >> ((16 - k) % 16)) & 1;
                count_high(i, n);
                check_eq($sformatf("R2/R3 ch%0d after %0d ticks", i, k), n, bitv * 1023);
            end
        end

        // R9: all-off pattern keeps the line dark despite full duty
        do_load(8'h8F, 8'h0F, 8'h0F);
        repeat (2100) @(negedge clk);
        count_high(0, n); check_eq("R9 red pattern 0x0000", n, 0);

        // R5: tick in the apply cycle is ignored (pattern 0x0F0F keeps bit 0)
        @(negedge clk);
        c_r = 8'h2F; c_g = 8'h2F; c_b = 8'h2F;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (1100) @(negedge clk);
        count_high(1, n); check_eq("R5 green gate after coincident tick", n, 1023);
        do_tick();
        count_high(1, n); check_eq("R5 green gate after one real tick", n, 0);

        // R8: new duty waits for the wrap of the running period
        do_load(8'h0F, 8'h0F, 8'h0F);
        repeat (2100) @(negedge clk);
        while (m_cnt[0] != 100) @(negedge clk);
        c_r = 8'h00;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        while (m_cnt[0] != 500) @(negedge clk);
        check_eq("R8 red old duty before wrap", led_out[0], 1);
        while (m_cnt[0] != 5) @(negedge clk);
        check_eq("R8 red new duty after wrap", led_out[0], 0);
        check_eq("R4 green loaded together keeps full duty", led_out[1] | led_out[2], 1);

        repeat (50) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule